// File: doc/BRIEF.md
# PCM Serial Voice Port

This block connects a codec core to a frame-synchronized PCM bus. It watches an external bit clock and frame sync and, once per frame, sends one voice word out on the serial data output while it captures one word from the serial data input. Every bus input is oversampled on a fast reference clock, so all of the logic runs in a single clock domain. The edges of the bit clock are found with edge detectors and choose when bits are launched and when they are sampled.

Three framing modes are supported. Two of them are non-delayed, where the first bit shares its bit period with the sync pulse, and differ only in which bit-clock edge launches and which captures. The third is delayed, where the first bit comes one bit period after the sync. A coding bit selects 14-bit linear words or 8-bit companded words. Words always travel most significant bit first. The output enable frames exactly the active bits. The output stays quiet after power-up until the second sync pulse, and it goes quiet at once when power is removed or the bit clock stops.

Words move to and from the core as valid/ready streams. On the transmit side, ready is a single-cycle pulse at the start of each transmitting slot. A word is consumed only when valid is high in that cycle. Otherwise an all-zero word is sent and the pending word waits for the next slot. On the receive side, a finished word raises valid, which stays high with the data held until ready is seen. A newer word that completes before acceptance replaces the older one.

Top module: `pcm_voice_port`

## Requirements
- R1: With cfg_comp_i=0 a slot carries 14 bits, taken from tx_data_i[13:0] and returned in rx_data_o[13:0]. With cfg_comp_i=1 it carries 8 bits, taken from tx_data_i[7:0] and returned in rx_data_o[7:0] with rx_data_o[13:8]=0. Bits go MSB first in both cases.
- R2: In mode cfg_mode_i=2'b00 (non-delayed, and also used for 2'b11) the first bit is launched on the bit-clock rising edge at which fs_i is first seen high, and dr_i is sampled on falling edges.
- R3: In mode cfg_mode_i=2'b01 (delayed) edges are used as in R2, but the first bit is launched on the rising edge one bit period after the one that first sees fs_i high.
- R4: In mode cfg_mode_i=2'b10 (non-delayed reverse) the roles of the edges swap: bits launch on falling edges, fs_i is checked at falling edges, and dr_i is sampled on rising edges.
- R5: dx_oe_o is high for exactly the word length of bit periods from the first launched bit and low outside the slot; dx_o is 0 while dx_oe_o is low.
- R6: After power_up_i rises, the slot tied to the first fs_i pulse keeps dx_oe_o low, and transmission begins with the slot tied to the second pulse. Reception runs from the first pulse.
- R7: While power_up_i is low, dx_oe_o is low from the next reference cycle on, no word is transmitted or received, and tx_ready_o stays low.
- R8: If mclk_i shows no edge for LOSS_LIMIT reference cycles, mclk_lost_o goes high and dx_oe_o goes low. Once edges return, transmission restarts only under the two-pulse rule of R6.
- R9: tx_ready_o is a one-cycle pulse at the start of each transmitting slot. If tx_valid_i is low in that cycle, an all-zero word is sent and no word is consumed.
- R10: rx_valid_o rises after the last bit of a slot is captured and stays high with rx_data_o held until rx_ready_i is high. A word completed before acceptance replaces the held one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock, much faster than the bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| power_up_i | input | 1 | 1 = port powered up, 0 = powered down |
| cfg_mode_i | input | 2 | Framing mode: 00 non-delayed, 01 delayed, 10 non-delayed reverse, 11 as 00 |
| cfg_comp_i | input | 1 | 0 = 14-bit linear words, 1 = 8-bit companded words |
| mclk_i | input | 1 | PCM bit clock |
| fs_i | input | 1 | Frame sync, high for one bit period |
| dr_i | input | 1 | Serial receive data |
| dx_o | output | 1 | Serial transmit data |
| dx_oe_o | output | 1 | Drive enable for dx_o; low means high impedance |
| mclk_lost_o | output | 1 | High while the bit clock is considered stopped |
| tx_data_i | input | 14 | Transmit word from the core |
| tx_valid_i | input | 1 | Transmit word valid |
| tx_ready_o | output | 1 | Transmit word accepted at slot start |
| rx_data_o | output | 14 | Received word |
| rx_valid_o | output | 1 | Received word valid |
| rx_ready_i | input | 1 | Core accepts the received word |

## Verification
The assertions assume that the bit clock is slow against the reference clock, with each half period several reference cycles longer than the synchronizer delay. They also assume that fs_i and dr_i never change at the same moment as the bit-clock edge that samples them. The stimulus keeps to this by holding each bit-clock phase for eight reference cycles. It changes fs_i only on the edge opposite the launch edge and changes dr_i only on launch edges, so that each one is stable for half a bit period around the edge that uses it. Under those conditions the output enable, ready and receive-hold properties follow the requirements from reset onward.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
  typedef enum logic [1:0] {
    FRM_ALIGNED  = 2'b00,
    FRM_DELAYED  = 2'b01,
    FRM_REVERSE  = 2'b10,
    FRM_SPARE    = 2'b11
  } frame_mode_e;

  localparam int LIN_BITS = 14;
  localparam int CMP_BITS = 8;
endpackage

// File: rtl/pcm_in_sync.sv
module pcm_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mclk_i,
  input  logic fs_i,
  input  logic dr_i,
  output logic mclk_rise_o,
  output logic mclk_fall_o,
  output logic fs_o,
  output logic dr_o
);
  // stage bits: [2] bit clock, [1] frame sync, [0] receive data
  logic [STAGES-1:0][2:0] stg;
  logic                   mclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg    <= '0;
      mclk_q <= 1'b0;
    end else begin
      stg    <= {stg[STAGES-2:0], {mclk_i, fs_i, dr_i}};
      mclk_q <= stg[STAGES-1][2];
    end
  end

  assign mclk_rise_o = stg[STAGES-1][2] & ~mclk_q;
  assign mclk_fall_o = ~stg[STAGES-1][2] & mclk_q;
  assign fs_o        = stg[STAGES-1][1];
  assign dr_o        = stg[STAGES-1][0];
endmodule

// File: rtl/pcm_clk_monitor.sv
module pcm_clk_monitor #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_i,
  output logic lost_o
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] idle_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    idle_cnt <= '0;
    else if (edge_i)               idle_cnt <= '0;
    else if (idle_cnt != CW'(LIMIT)) idle_cnt <= idle_cnt + 1'b1;
  end

  // an edge in the current cycle ends the lost state at once
  assign lost_o = (idle_cnt == CW'(LIMIT)) && !edge_i;
endmodule

// File: rtl/pcm_tx_lane.sv
module pcm_tx_lane #(
  parameter int W_MAX = 14,
  localparam int NB_W = $clog2(W_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             start_i,
  input  logic             launch_i,
  input  logic [NB_W-1:0]  nbits_i,
  input  logic [W_MAX-1:0] word_i,
  output logic             dx_o,
  output logic             oe_o
);
  logic [W_MAX-1:0] sh;
  logic [NB_W-1:0]  left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      left <= '0;
      oe_o <= 1'b0;
    end else if (!run_i) begin
      oe_o <= 1'b0;
      left <= '0;
    end else if (start_i) begin
      sh   <= word_i;
      left <= nbits_i - NB_W'(1);
      oe_o <= 1'b1;
    end else if (launch_i && oe_o) begin
      if (left == '0) begin
        oe_o <= 1'b0;
      end else begin
        sh   <= {sh[W_MAX-2:0], 1'b0};
        left <= left - 1'b1;
      end
    end
  end

  assign dx_o = oe_o & sh[W_MAX-1];
endmodule

// File: rtl/pcm_rx_lane.sv
module pcm_rx_lane #(
  parameter int W_MAX = 14,
  localparam int NB_W = $clog2(W_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             start_i,
  input  logic             capture_i,
  input  logic             dr_i,
  input  logic [NB_W-1:0]  nbits_i,
  output logic [W_MAX-1:0] word_o,
  output logic             done_o
);
  logic [NB_W-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_o <= '0;
      left   <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!run_i) begin
        left <= '0;
      end else if (start_i) begin
        word_o <= '0;
        left   <= nbits_i;
      end else if (capture_i && left != '0) begin
        word_o <= {word_o[W_MAX-2:0], dr_i};
        left   <= left - 1'b1;
        done_o <= (left == NB_W'(1));
      end
    end
  end
endmodule

// File: rtl/pcm_voice_port.sv
module pcm_voice_port
  import pcm_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LOSS_LIMIT  = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                power_up_i,
  input  logic [1:0]          cfg_mode_i,
  input  logic                cfg_comp_i,
  input  logic                mclk_i,
  input  logic                fs_i,
  input  logic                dr_i,
  output logic                dx_o,
  output logic                dx_oe_o,
  output logic                mclk_lost_o,
  input  logic [LIN_BITS-1:0] tx_data_i,
  input  logic                tx_valid_i,
  output logic                tx_ready_o,
  output logic [LIN_BITS-1:0] rx_data_o,
  output logic                rx_valid_o,
  input  logic                rx_ready_i
);
  localparam int NB_W = $clog2(LIN_BITS + 1);
  localparam int PAD  = LIN_BITS - CMP_BITS;

  logic rise, fall, fs_s, dr_s;
  logic launch, capture, run, delayed;
  logic [1:0] fs_hist;
  logic [1:0] blank_cnt;
  logic fs_event, slot_start, tx_go;
  logic [NB_W-1:0] nbits;
  logic [LIN_BITS-1:0] tx_word, rx_word;
  logic rx_done;
  frame_mode_e mode;

  assign mode = frame_mode_e'(cfg_mode_i);

  pcm_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .mclk_i(mclk_i), .fs_i(fs_i), .dr_i(dr_i),
    .mclk_rise_o(rise), .mclk_fall_o(fall), .fs_o(fs_s), .dr_o(dr_s)
  );

  pcm_clk_monitor #(.LIMIT(LOSS_LIMIT)) u_mon (
    .clk(clk), .rst_n(rst_n), .edge_i(rise | fall), .lost_o(mclk_lost_o)
  );

  // edge roles follow the framing mode
  assign launch  = (mode == FRM_REVERSE) ? fall : rise;
  assign capture = (mode == FRM_REVERSE) ? rise : fall;
  assign delayed = (mode == FRM_DELAYED);
  assign run     = power_up_i & ~mclk_lost_o;

  assign fs_event   = run & launch & fs_s & ~fs_hist[0];
  assign slot_start = delayed ? (run & launch & fs_hist[0] & ~fs_hist[1]) : fs_event;
  assign tx_go      = slot_start & (delayed ? (blank_cnt == 2'd2) : (blank_cnt != 2'd0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_hist   <= '0;
      blank_cnt <= '0;
    end else if (!run) begin
      fs_hist   <= '0;
      blank_cnt <= '0;
    end else begin
      if (launch)                          fs_hist   <= {fs_hist[0], fs_s};
      if (fs_event && blank_cnt != 2'd2)   blank_cnt <= blank_cnt + 1'b1;
    end
  end

  assign nbits = cfg_comp_i ? NB_W'(CMP_BITS) : NB_W'(LIN_BITS);

  always_comb begin
    if (!tx_valid_i)     tx_word = '0;
    else if (cfg_comp_i) tx_word = {tx_data_i[CMP_BITS-1:0], {PAD{1'b0}}};
    else                 tx_word = tx_data_i;
  end

  assign tx_ready_o = tx_go;

  pcm_tx_lane #(.W_MAX(LIN_BITS)) u_tx (
    .clk(clk), .rst_n(rst_n), .run_i(run), .start_i(tx_go), .launch_i(launch),
    .nbits_i(nbits), .word_i(tx_word), .dx_o(dx_o), .oe_o(dx_oe_o)
  );

  pcm_rx_lane #(.W_MAX(LIN_BITS)) u_rx (
    .clk(clk), .rst_n(rst_n), .run_i(run), .start_i(slot_start), .capture_i(capture),
    .dr_i(dr_s), .nbits_i(nbits), .word_o(rx_word), .done_o(rx_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data_o  <= '0;
      rx_valid_o <= 1'b0;
    end else if (rx_done) begin
      rx_data_o  <= rx_word;
      rx_valid_o <= 1'b1;
    end else if (rx_ready_i) begin
      rx_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pcm_voice_port_sva.sv
module pcm_voice_port_sva (
  input logic clk,
  input logic rst_n,
  input logic power_up_i,
  input logic dx_oe_o,
  input logic mclk_lost_o,
  input logic tx_ready_o,
  input logic rx_valid_o,
  input logic rx_ready_i
);
  assert_quiet_when_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !power_up_i |=> !dx_oe_o);

  assert_no_ready_when_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !power_up_i |-> !tx_ready_o);

  assert_quiet_when_lost_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mclk_lost_o |=> !dx_oe_o);

  assert_ready_opens_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready_o |=> dx_oe_o);

  assert_ready_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready_o |=> !tx_ready_o);

  assert_rx_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_o && !rx_ready_i) |=> rx_valid_o);
endmodule

bind pcm_voice_port pcm_voice_port_sva u_sva (
  .clk(clk), .rst_n(rst_n), .power_up_i(power_up_i), .dx_oe_o(dx_oe_o),
  .mclk_lost_o(mclk_lost_o), .tx_ready_o(tx_ready_o),
  .rx_valid_o(rx_valid_o), .rx_ready_i(rx_ready_i)
);

// File: tb/pcm_voice_port_tb.sv
module pcm_voice_port_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic power_up = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic cfg_comp = 1'b0;
  logic mclk = 1'b0, fs = 1'b0, dr = 1'b0;
  logic dx, dx_oe, lost;
  logic [13:0] tx_data = '0;
  logic tx_valid = 1'b0;
  logic tx_ready;
  logic [13:0] rx_data;
  logic rx_valid;
  logic rx_ready = 1'b0;

  int checks = 0;
  int failures = 0;
  int hs_cnt = 0;
  bit done = 0;
  localparam int FRAME = 20;

  always #4 clk = ~clk;

  pcm_voice_port u_dut (
    .clk(clk), .rst_n(rst_n), .power_up_i(power_up), .cfg_mode_i(cfg_mode),
    .cfg_comp_i(cfg_comp), .mclk_i(mclk), .fs_i(fs), .dr_i(dr),
    .dx_o(dx), .dx_oe_o(dx_oe), .mclk_lost_o(lost),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_ready_i(rx_ready)
  );

  always @(posedge clk) if (tx_valid && tx_ready) hs_cnt <= hs_cnt + 1;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one full frame: FS pulse, slot bits, checks of DX pattern and word
  task automatic run_frame(input logic [1:0] mode, input logic cm, input logic [13:0] exp_tx,
                           input logic [13:0] rxw, input bit expect_tx, input string req);
    int w = cm ? 8 : 14;
    int off = (mode == 2'b01) ? 1 : 0;
    logic lv = (mode == 2'b10) ? 1'b0 : 1'b1;
    int oe_cnt = 0;
    int oe_bad = 0;
    logic [13:0] got = '0;
    cfg_mode = mode;
    cfg_comp = cm;
    mclk = ~lv;
    fs = 1'b1;
    tick(8);
    for (int p = 0; p < FRAME; p++) begin
      int k = p - off;
      bit inslot = (k >= 0) && (k < w);
      mclk = lv;
      dr = inslot ? rxw[w-1-k] : 1'b1;
      tick(7);
      if (dx_oe) oe_cnt++;
      if (dx_oe !== (inslot && expect_tx)) oe_bad++;
      if (!dx_oe && dx !== 1'b0) oe_bad++;
      if (inslot) got = {got[12:0], dx};
      tick(1);
      mclk = ~lv;
      if (p == 0) fs = 1'b0;
      tick(8);
    end
    check(oe_bad == 0, req, "dx enable window count", oe_cnt, expect_tx ? w : 0);
    if (expect_tx) check(got == exp_tx, req, "dx word", got, exp_tx);
  endtask

  task automatic check_rx(input logic [13:0] exp, input string req, input bit accept);
    check(rx_valid === 1'b1, req, "rx_valid", rx_valid, 1);
    check(rx_data === exp, req, "rx_data", rx_data, exp);
    if (accept) begin
      rx_ready = 1'b1;
      tick(1);
      rx_ready = 1'b0;
      tick(1);
      check(rx_valid === 1'b0, "R10", "rx_valid after accept", rx_valid, 0);
    end
  endtask

  task automatic t_reset;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    check(dx_oe === 1'b0, "R7", "reset dx_oe", dx_oe, 0);
    check(tx_ready === 1'b0 && rx_valid === 1'b0, "R7", "reset handshakes", {tx_ready, rx_valid}, 0);
    check(lost === 1'b0, "R8", "reset lost", lost, 0);
  endtask

  task automatic t_blank_then_normal;
    int h0;
    power_up = 1'b1;
    tx_data = 14'h2A5C;
    tx_valid = 1'b1;
    h0 = hs_cnt;
    run_frame(2'b00, 1'b0, 14'h2A5C, 14'h1337, 1'b0, "R6");
    check_rx(14'h1337, "R6", 1'b1);
    check(hs_cnt == h0, "R6", "no handshake in blank frame", hs_cnt - h0, 0);
    run_frame(2'b00, 1'b0, 14'h2A5C, 14'h0F0F, 1'b1, "R2");
    check_rx(14'h0F0F, "R2", 1'b1);
    check(hs_cnt == h0 + 1, "R9", "one handshake per slot", hs_cnt - h0, 1);
  endtask

  task automatic t_delayed;
    tx_data = 14'h1C3B;
    run_frame(2'b01, 1'b0, 14'h1C3B, 14'h2461, 1'b1, "R3");
    check_rx(14'h2461, "R3", 1'b1);
  endtask

  task automatic t_reverse;
    tx_data = 14'h3FFE;
    run_frame(2'b10, 1'b0, 14'h3FFE, 14'h0001, 1'b1, "R4");
    check_rx(14'h0001, "R4", 1'b1);
  endtask

  task automatic t_companded;
    tx_data = 14'h3E96;
    run_frame(2'b00, 1'b1, 14'h0096, 14'h00C3, 1'b1, "R1");
    check_rx(14'h00C3, "R1", 1'b1);
    run_frame(2'b10, 1'b1, 14'h0096, 14'h005A, 1'b1, "R1");
    check_rx(14'h005A, "R1", 1'b1);
  endtask

  task automatic t_idle_word;
    int h0 = hs_cnt;
    tx_valid = 1'b0;
    run_frame(2'b00, 1'b0, 14'h0000, 14'h0555, 1'b1, "R9");
    check(hs_cnt == h0, "R9", "no consume when invalid", hs_cnt - h0, 0);
    check_rx(14'h0555, "R5", 1'b1);
    tx_valid = 1'b1;
  endtask

  task automatic t_backpressure;
    run_frame(2'b00, 1'b0, tx_data, 14'h1111, 1'b1, "R10");
    tick(20);
    check_rx(14'h1111, "R10", 1'b0);
    run_frame(2'b00, 1'b0, tx_data, 14'h2222, 1'b1, "R10");
    check_rx(14'h2222, "R10", 1'b1);
  endtask

  task automatic t_power_down;
    power_up = 1'b0;
    tick(2);
    check(dx_oe === 1'b0, "R7", "dx_oe after power down", dx_oe, 0);
    run_frame(2'b00, 1'b0, tx_data, 14'h0ABC, 1'b0, "R7");
    check(rx_valid === 1'b0, "R7", "no rx while down", rx_valid, 0);
    power_up = 1'b1;
    run_frame(2'b00, 1'b0, tx_data, 14'h0123, 1'b0, "R6");
    check_rx(14'h0123, "R6", 1'b1);
    run_frame(2'b00, 1'b0, tx_data, 14'h0321, 1'b1, "R6");
    check_rx(14'h0321, "R6", 1'b1);
  endtask

  task automatic t_clock_loss;
    tick(100);
    check(lost === 1'b1, "R8", "lost after idle", lost, 1);
    check(dx_oe === 1'b0, "R8", "dx_oe while lost", dx_oe, 0);
    tx_data = 14'h1A2B;
    run_frame(2'b00, 1'b0, 14'h1A2B, 14'h0707, 1'b0, "R8");
    check(lost === 1'b0, "R8", "lost clears with edges", lost, 0);
    check_rx(14'h0707, "R8", 1'b1);
    run_frame(2'b00, 1'b0, 14'h1A2B, 14'h3003, 1'b1, "R8");
    check_rx(14'h3003, "R8", 1'b1);
  endtask

  initial begin
    t_reset();
    t_blank_then_normal();
    t_delayed();
    t_reverse();
    t_companded();
    t_idle_word();
    t_backpressure();
    t_power_down();
    t_clock_loss();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(150000);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule